// File: doc/BRIEF.md
# Per-Phase Low-Power State Controller

This block decides, for one phase of a multiphase converter, when that phase leaves the interleaved chain for a light-load state and when it returns. An active-low request comes in without any timing relation to the system clock. The block synchronises the request and counts rising edges of the phase clock while it stays asserted. Only after eight uninterrupted edges does it raise a synchronised low-power flag. The request is released later, and the flag drops on the next phase-clock rising edge.

While the flag is high, the block does four things. It forces both gate-drive outputs low and asserts the drivers' float enable. It disconnects the current-share output. It routes the synchronised phase input straight to the phase output, so the one-cycle phase delay flop is skipped. The cycle-by-cycle overcurrent blanking keeps working as it does outside the state. Each change of the flag is reported to the central controller on a three-level status line. The line is modelled as two drive enables; when neither is set, the line floats at mid-level. A short low pulse marks a phase leaving the chain and a short high pulse marks a phase joining it. The pulse width is a parameter counted in system clocks.

Top module: `phase_lowpower_ctl`

## Requirements
- R1: After synchronous reset, `ps_active`, `drv_float`, `shift_up`, `shift_dn` and `oc_hit` are 0, `share_en` is 1 and `phs_out` is 0.
- R2: `req_n` is active low. After it has been low (through a two-flop synchroniser) for 8 consecutive rising edges of the synchronised `phs_in`, `ps_active` becomes 1. It is still 0 after 7 such edges.
- R3: If the request is released before the 8th edge, `ps_active` stays 0 and the edge count restarts from zero. A new request then again needs 8 full edges.
- R4: Once `req_n` returns high, `ps_active` falls on the first synchronised rising edge of `phs_in`, and it changes at no other time.
- R5: While `ps_active` is 1, `hs_drive` and `ls_drive` are 0 and `drv_float` is 1, whatever `hs_req` and `ls_req` are. Otherwise `drv_float` is 0 and `ls_drive` follows `ls_req`, and `hs_drive` follows `hs_req` unless overcurrent blanking (R10) is set.
- R6: `share_en` is 0 exactly while `ps_active` is 1.
- R7: Outside the state, `phs_out` changes only on a cycle with `clk_pulse` high, where it takes the synchronised `phs_in`. Inside the state, it equals the synchronised `phs_in` (two cycles behind `phs_in`).
- R8: Entry produces a low pulse on the status line: `shift_dn` is high for exactly PULSE_CYC system clocks (default 3), starting one cycle after `ps_active` rises. `shift_up` stays 0 during this pulse.
- R9: Exit produces a high pulse: `shift_up` is high for exactly PULSE_CYC clocks, starting one cycle after `ps_active` falls. `shift_up` and `shift_dn` are never both 1.
- R10: An `oc_trip` cycle sets `oc_hit` on the next clock and holds `hs_drive` at 0 until the next synchronised `phs_in` rising edge clears it. This works in both states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_n | input | 1 | Asynchronous low-power request, active low |
| phs_in | input | 1 | Phase clock from the previous stage of the chain |
| clk_pulse | input | 1 | One-cycle strobe that loads the phase delay flop |
| hs_req | input | 1 | High-side drive request from the PWM |
| ls_req | input | 1 | Low-side drive request from the PWM |
| oc_trip | input | 1 | Overcurrent comparator output |
| hs_drive | output | 1 | High-side gate enable |
| ls_drive | output | 1 | Low-side gate enable |
| drv_float | output | 1 | Drivers to high impedance |
| share_en | output | 1 | Current-share output connect |
| phs_out | output | 1 | Phase clock to the next stage |
| oc_hit | output | 1 | Overcurrent blanking active |
| shift_up | output | 1 | Drive status line high (phase joined) |
| shift_dn | output | 1 | Drive status line low (phase left) |
| ps_active | output | 1 | Synchronised low-power flag |

## Verification
The assertions check the following on every cycle:
- the flag changes only on a phase edge, and the edge counter stays in range;
- the drivers are forced low and the share output is disconnected whenever the flag is set;
- the status line is never driven both ways, and each change of the flag is followed by a pulse in the matching direction;
- the phase output holds while no strobe arrives;
- an overcurrent trip blanks the high side.

Some properties are visible only over a scenario, so the bench covers them. These are:
- the exact count of 8 edges before entry;
- the restart of the count after a short request;
- the exact pulse widths;
- the sweep of drive-request combinations in and out of the state.

// File: rtl/plp_pkg.sv
package plp_pkg;

    typedef enum logic [1:0] {
        SH_IDLE = 2'd0,
        SH_UP   = 2'd1,
        SH_DN   = 2'd2
    } shift_dir_e;

    typedef struct packed {
        logic up;
        logic dn;
    } shift_line_t;

    function automatic shift_dir_e dir_of_change(input logic new_flag);
        return new_flag ? SH_DN : SH_UP;
    endfunction

    function automatic shift_line_t line_of(input shift_dir_e d, input logic busy);
        shift_line_t l;
        l.up = busy && (d == SH_UP);
        l.dn = busy && (d == SH_DN);
        return l;
    endfunction

endpackage

// File: rtl/plp_phase_path.sv
module plp_phase_path (
    input  logic clk,
    input  logic rst,
    input  logic phs_in,
    input  logic clk_pulse,
    input  logic bypass,
    output logic phs_sync,
    output logic phs_rise,
    output logic phs_out
);
    logic s1, s2, s2_d, dly;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1   <= 1'b0;
            s2   <= 1'b0;
            s2_d <= 1'b0;
            dly  <= 1'b0;
        end else begin
            s1   <= phs_in;
            s2   <= s1;
            s2_d <= s2;
            if (clk_pulse) dly <= s2;
        end
    end

    assign phs_sync = s2;
    assign phs_rise = s2 && !s2_d;
    assign phs_out  = bypass ? s2 : dly;

    // R7: with no strobe and no bypass, the phase output holds
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!bypass && !$past(bypass) && !$past(clk_pulse) && !$past(rst)) |-> $stable(phs_out));

endmodule

// File: rtl/plp_req_filter.sv
module plp_req_filter #(
    parameter int ENTRY_EDGES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic req_n,
    input  logic phs_rise,
    output logic flag
);
    localparam int CNT_W = (ENTRY_EDGES > 1) ? $clog2(ENTRY_EDGES) : 1;

    logic             r1, r2;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            r1   <= 1'b0;
            r2   <= 1'b0;
            cnt  <= '0;
            flag <= 1'b0;
        end else begin
            r1 <= !req_n;
            r2 <= r1;
            if (!r2) cnt <= '0;
            if (phs_rise) begin
                if (!flag) begin
                    if (r2) begin
                        if (cnt == CNT_W'(ENTRY_EDGES - 1)) begin
                            flag <= 1'b1;
                            cnt  <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end else if (!r2) begin
                    flag <= 1'b0;
                end
            end
        end
    end

    // R2: edge counter never exceeds the entry count
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
        int'(cnt) < ENTRY_EDGES);

    // R4: the flag moves only right after a phase edge
    p_flag_on_edge_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (flag != $past(flag))) |-> $past(phs_rise));

    // R3: a released request leaves the counter cleared
    p_cnt_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(r2)) |-> (cnt == '0));

endmodule

// File: rtl/plp_shift_pulse.sv
module plp_shift_pulse
    import plp_pkg::*;
#(
    parameter int PULSE_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic flag,
    output logic up,
    output logic dn
);
    localparam int PW_W = $clog2(PULSE_CYC + 1);

    logic            flag_d;
    logic [PW_W-1:0] left;
    shift_dir_e      dir;
    shift_line_t     line;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_d <= 1'b0;
            left   <= '0;
            dir    <= SH_IDLE;
        end else begin
            flag_d <= flag;
            if (flag != flag_d) begin
                left <= PW_W'(PULSE_CYC);
                dir  <= dir_of_change(flag);
            end else if (left != '0) begin
                left <= left - 1'b1;
            end
        end
    end

    assign line = line_of(dir, left != '0);
    assign up   = line.up;
    assign dn   = line.dn;

    // R9: status line never driven both ways
    p_excl_r9: assert property (@(posedge clk) disable iff (rst) !(up && dn));

    // R8: entry is followed by a low pulse
    p_dn_after_entry_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(flag)) |=> dn);

    // R9: exit is followed by a high pulse
    p_up_after_exit_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(flag)) |=> up);

endmodule

// File: rtl/phase_lowpower_ctl.sv
module phase_lowpower_ctl #(
    parameter int ENTRY_EDGES = 8,
    parameter int PULSE_CYC   = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic req_n,
    input  logic phs_in,
    input  logic clk_pulse,
    input  logic hs_req,
    input  logic ls_req,
    input  logic oc_trip,
    output logic hs_drive,
    output logic ls_drive,
    output logic drv_float,
    output logic share_en,
    output logic phs_out,
    output logic oc_hit,
    output logic shift_up,
    output logic shift_dn,
    output logic ps_active
);
    logic phs_sync, phs_rise, flag, oc_blk;

    plp_phase_path u_phase (
        .clk       (clk),
        .rst       (rst),
        .phs_in    (phs_in),
        .clk_pulse (clk_pulse),
        .bypass    (flag),
        .phs_sync  (phs_sync),
        .phs_rise  (phs_rise),
        .phs_out   (phs_out)
    );

    plp_req_filter #(.ENTRY_EDGES(ENTRY_EDGES)) u_filter (
        .clk      (clk),
        .rst      (rst),
        .req_n    (req_n),
        .phs_rise (phs_rise),
        .flag     (flag)
    );

    plp_shift_pulse #(.PULSE_CYC(PULSE_CYC)) u_shift (
        .clk  (clk),
        .rst  (rst),
        .flag (flag),
        .up   (shift_up),
        .dn   (shift_dn)
    );

    always_ff @(posedge clk) begin
        if (rst)           oc_blk <= 1'b0;
        else if (oc_trip)  oc_blk <= 1'b1;
        else if (phs_rise) oc_blk <= 1'b0;
    end

    assign hs_drive  = hs_req && !flag && !oc_blk;
    assign ls_drive  = ls_req && !flag;
    assign drv_float = flag;
    assign share_en  = !flag;
    assign oc_hit    = oc_blk;
    assign ps_active = flag;

    // R5: drivers parked in the low-power state
    p_drv_parked_r5: assert property (@(posedge clk) disable iff (rst)
        ps_active |-> (drv_float && !hs_drive && !ls_drive));

    // R6: share output detached in the low-power state
    p_share_off_r6: assert property (@(posedge clk) disable iff (rst)
        ps_active |-> !share_en);

    // R10: a trip blanks the high side on the following cycle
    p_oc_blank_r10: assert property (@(posedge clk) disable iff (rst)
        $past(oc_trip && !rst) |-> (!hs_drive && oc_hit));

endmodule

// File: tb/test_phase_lowpower_ctl.sv
module test_phase_lowpower_ctl;
    localparam int PW = 3;

    logic clk = 1'b0, rst = 1'b1;
    logic req_n = 1'b1, phs_in = 1'b0, clk_pulse = 1'b0;
    logic hs_req = 1'b0, ls_req = 1'b0, oc_trip = 1'b0;
    logic hs_drive, ls_drive, drv_float, share_en, phs_out, oc_hit;
    logic shift_up, shift_dn, ps_active;

    int n_chk = 0, n_bad = 0;
    int up_tot = 0, dn_tot = 0;
    int up_base, dn_base;
    bit done = 1'b0;

    always #10 clk = ~clk;

    phase_lowpower_ctl #(.ENTRY_EDGES(8), .PULSE_CYC(PW)) i_phase_lowpower_ctl (
        .clk(clk), .rst(rst), .req_n(req_n), .phs_in(phs_in), .clk_pulse(clk_pulse),
        .hs_req(hs_req), .ls_req(ls_req), .oc_trip(oc_trip),
        .hs_drive(hs_drive), .ls_drive(ls_drive), .drv_float(drv_float),
        .share_en(share_en), .phs_out(phs_out), .oc_hit(oc_hit),
        .shift_up(shift_up), .shift_dn(shift_dn), .ps_active(ps_active)
    );

    always @(negedge clk) begin
        if (shift_up) up_tot <= up_tot + 1;
        if (shift_dn) dn_tot <= dn_tot + 1;
    end

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic period(input int n);
        for (int i = 0; i < n; i++) begin
            phs_in = 1'b1; cyc(4);
            phs_in = 1'b0; cyc(4);
        end
    endtask

    task automatic mark();
        cyc(1);
        up_base = up_tot;
        dn_base = dn_tot;
    endtask

    initial begin
        cyc(3);
        chk("R1 ps_active", ps_active, 0);
        chk("R1 drv_float", drv_float, 0);
        chk("R1 share_en", share_en, 1);
        chk("R1 shift", {shift_up, shift_dn}, 0);
        chk("R1 oc_hit", oc_hit, 0);
        chk("R1 phs_out", phs_out, 0);
        rst = 1'b0;
        cyc(2);

        // R7 normal: phase output waits for the strobe
        phs_in = 1'b1; cyc(4);
        chk("R7 hold without strobe", phs_out, 0);
        clk_pulse = 1'b1; cyc(1); clk_pulse = 1'b0;
        chk("R7 load on strobe", phs_out, 1);
        phs_in = 1'b0; cyc(4);
        chk("R7 hold after input falls", phs_out, 1);
        clk_pulse = 1'b1; cyc(1); clk_pulse = 1'b0;
        chk("R7 reload on strobe", phs_out, 0);

        // R5 sweep outside the state
        for (int k = 0; k < 4; k++) begin
            hs_req = k[0]; ls_req = k[1]; cyc(1);
            chk("R5 hs follows", hs_drive, k[0]);
            chk("R5 ls follows", ls_drive, k[1]);
            chk("R5 no float", drv_float, 0);
        end
        hs_req = 1'b0; ls_req = 1'b0;

        // R3 short request then restart
        mark();
        req_n = 1'b0; cyc(2);
        period(5);
        req_n = 1'b1; cyc(2);
        period(4);
        chk("R3 short request ignored", ps_active, 0);
        chk("R3 no down pulse", dn_tot - dn_base, 0);
        req_n = 1'b0; cyc(2);
        period(7);
        chk("R3 count restarted (7 edges)", ps_active, 0);
        chk("R2 not after 7 edges", ps_active, 0);
        period(1);
        chk("R2 entry on 8th edge", ps_active, 1);
        cyc(4);
        chk("R8 down pulse width", dn_tot - dn_base, PW);
        chk("R8 no up pulse", up_tot - up_base, 0);
        chk("R6 share detached", share_en, 0);

        // R5 sweep inside the state
        for (int k = 0; k < 4; k++) begin
            hs_req = k[0]; ls_req = k[1]; cyc(1);
            chk("R5 hs parked", hs_drive, 0);
            chk("R5 ls parked", ls_drive, 0);
            chk("R5 float", drv_float, 1);
        end
        hs_req = 1'b0; ls_req = 1'b0;

        // R7 bypass
        phs_in = 1'b1; cyc(3);
        chk("R7 bypass high", phs_out, 1);
        phs_in = 1'b0; cyc(3);
        chk("R7 bypass low", phs_out, 0);

        // R10 inside the state
        oc_trip = 1'b1; cyc(1); oc_trip = 1'b0;
        chk("R10 oc in state", oc_hit, 1);
        period(1);
        chk("R10 cleared by edge", oc_hit, 0);

        // R4 and R9 exit
        mark();
        req_n = 1'b1; cyc(6);
        chk("R4 waits for edge", ps_active, 1);
        phs_in = 1'b1; cyc(4);
        chk("R4 exit on edge", ps_active, 0);
        phs_in = 1'b0; cyc(4);
        chk("R9 up pulse width", up_tot - up_base, PW);
        chk("R9 no down pulse", dn_tot - dn_base, 0);
        chk("R6 share back", share_en, 1);

        // R10 outside the state
        hs_req = 1'b1; cyc(1);
        chk("R10 hs before trip", hs_drive, 1);
        oc_trip = 1'b1; cyc(1); oc_trip = 1'b0;
        chk("R10 hs blanked", hs_drive, 0);
        cyc(2);
        chk("R10 held until edge", hs_drive, 0);
        period(1);
        chk("R10 hs restored", hs_drive, 1);
        hs_req = 1'b0;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule